// File: doc/BRIEF.md
# Stacked Interrupt Status Controller

This block gathers interrupt events from two producers, a bus-protocol engine and a DMA engine, into host-visible status bytes and drives one active-low interrupt request. The protocol side owns a bank of status bytes. The DMA side owns one byte. Each visible byte has a shadow byte behind it. Once a source already has an unmasked bit pending, its later events go into the shadow byte and do not disturb the status the host is about to read.

When the host reads a visible status byte, that byte clears. The request line is then forced inactive for a fixed gap, and after the gap the shadow contents move into view. The request reasserts if anything unmasked is showing. Nonfatal bits can be disabled per bit. A disabled bit still appears in status, but it raises no request and does not cause stacking. Fatal bits ignore the enable mask. Protocol events are held back while the DMA FIFO is not empty and are posted on the cycle it reports empty. The host can also write a control register that issues one-cycle FIFO-clear pulses.

Top module: `irq_stack_ctrl`

## Requirements
- R1: Address `i` for `i < N_PROTO_REGS` shows protocol status byte `i` (event bits `8i+7..8i`), and address `N_PROTO_REGS` shows the DMA status byte. `rd_data` always presents the addressed register, whether or not `rd_en` is high. A posted event sets its bit.
- R2: `irq_n` is low when any visible status bit is set whose enable is 1 or which is fatal, and no gap is running. Address `N_PROTO_REGS+1` reads the pending register: bit 0 is protocol pending and bit 1 is DMA pending. Reading it clears nothing.
- R3: A read (`rd_en`) of a status address clears that byte and holds `irq_n` high for `GAP_CYCLES` cycles (default 3), beginning the cycle after the read.
- R4: An event that arrives while its own source's pending bit is set goes to the shadow byte and does not appear in status. On the edge that ends the gap it is ORed into the visible byte and the shadow clears.
- R5: An event whose enable bit is 0 and which is not fatal still sets its status bit, but it raises no request and causes no stacking. Later events post directly and the earlier bit stays set.
- R6: Fatal bits (protocol bit 0 of each byte, DMA bit 0 by default) raise the request whatever their enable bit is.
- R7: Events that arrive in the same cycle, from one source or from both, while no pending bit is set all post directly to status.
- R8: While `dma_fifo_empty` is low, protocol events do not post and are accumulated. They post on the first cycle `dma_fifo_empty` is high. DMA events are never held.
- R9: A write (`wr_en`) to address `N_PROTO_REGS+1` pulses `dma_fifo_clr` for one cycle if `wr_data[0]` is 1, and pulses `proto_fifo_clr` if `wr_data[1]` is 1. The pulse comes the cycle after the write. Writes to other addresses have no effect.
- R10: An event that arrives during the gap goes to the shadow byte for any source, and it is promoted with the rest on the gap's final edge.
- R11: After reset, every status byte, shadow byte, lockout store and FIFO-clear output is zero and `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proto_evt | input | 16 | Protocol event pulses |
| dma_evt | input | 8 | DMA event pulses |
| proto_ien | input | 16 | Protocol enables (1 = raises request) |
| dma_ien | input | 8 | DMA enables (1 = raises request) |
| dma_fifo_empty | input | 1 | DMA FIFO holds no data |
| rd_en | input | 1 | Host read strobe |
| wr_en | input | 1 | Host write strobe |
| addr | input | 2 | Register address |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Addressed register contents |
| irq_n | output | 1 | Active-low interrupt request |
| dma_fifo_clr | output | 1 | One-cycle DMA FIFO clear pulse |
| proto_fifo_clr | output | 1 | One-cycle protocol FIFO clear pulse |

## Verification
Two collisions matter most. One is a host read-to-clear landing on the same edge as a new event for the byte being cleared. The other is the final gap edge, where promotion meets a fresh event. The bench provokes both by issuing an event in the cycle of a read and during the gap. A behavioural reference model then has to agree, on every cycle, on which bits are visible and on `irq_n`: a fresh event must never be lost to the clear, and promotion must absorb it.

// File: rtl/irq_stack_pkg.sv
package irq_stack_pkg;
  typedef enum logic [1:0] {
    SEL_PROTO = 2'd0,
    SEL_DMA   = 2'd1,
    SEL_PEND  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_fifo_lockout.sv
module irq_fifo_lockout #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         fifo_empty,
  output logic [W-1:0] post
);
  logic [W-1:0] held_q, held_d;

  always_comb begin
    held_d = held_q;
    post   = '0;
    if (fifo_empty) begin
      post   = held_q | evt;
      held_d = '0;
    end else begin
      held_d = held_q | evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  // R8: events held during a full FIFO are released on the empty edge
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fifo_empty) && $past(evt) != '0) |-> ((post & $past(evt)) == $past(evt)));
endmodule

// File: rtl/irq_gap_timer.sv
module irq_gap_timer #(
  parameter int GAP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic promote
);
  localparam int CW = $clog2(GAP + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)            cnt_d = CW'(GAP);
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign active  = (cnt_q != '0);
  assign promote = (cnt_q == CW'(1));
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         push,
  input  logic         promote,
  input  logic         clr,
  output logic [W-1:0] vis,
  output logic [W-1:0] stk
);
  logic [W-1:0] vis_d, stk_d, kept;

  always_comb begin
    kept  = clr ? '0 : vis;
    vis_d = kept;
    stk_d = stk;
    if (promote) begin
      vis_d = kept | stk | evt;
      stk_d = '0;
    end else if (push) begin
      stk_d = stk | evt;
    end else begin
      vis_d = kept | evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vis <= '0;
      stk <= '0;
    end else begin
      vis <= vis_d;
      stk <= stk_d;
    end
  end

  // R4: pushed events are retained in the shadow byte
  p_stack_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !promote) |=> ((stk & $past(evt)) == $past(evt)));
  // R4: promotion moves the shadow contents into view
  p_promote_r4: assert property (@(posedge clk) disable iff (!rst_n)
    promote |=> (((vis & $past(stk)) == $past(stk)) && stk == '0));
  // R3: a read with no incoming event leaves the byte empty
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !promote && evt == '0) |=> vis == '0);
endmodule

// File: rtl/irq_stack_ctrl.sv
module irq_stack_ctrl
  import irq_stack_pkg::*;
#(
  parameter int REG_W        = 8,
  parameter int N_PROTO_REGS = 2,
  parameter int GAP_CYCLES   = 3,
  parameter logic [REG_W*N_PROTO_REGS-1:0] PROTO_FATAL = 16'h0101,
  parameter logic [REG_W-1:0]              DMA_FATAL   = 8'h01,
  localparam int PW     = REG_W * N_PROTO_REGS,
  localparam int ADDR_W = $clog2(N_PROTO_REGS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PW-1:0]     proto_evt,
  input  logic [REG_W-1:0]  dma_evt,
  input  logic [PW-1:0]     proto_ien,
  input  logic [REG_W-1:0]  dma_ien,
  input  logic              dma_fifo_empty,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic              irq_n,
  output logic              dma_fifo_clr,
  output logic              proto_fifo_clr
);
  localparam logic [ADDR_W-1:0] A_DMA  = ADDR_W'(N_PROTO_REGS);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(N_PROTO_REGS + 1);

  logic [PW-1:0]    proto_post, vis_p, stk_p;
  logic [REG_W-1:0] vis_d, stk_d;
  logic [N_PROTO_REGS-1:0] clr_p;
  logic clr_d, rd_clr, gap_act, gap_promote;
  logic sip, dip;
  logic dclr_q, dclr_d, pclr_q, pclr_d;
  reg_sel_e sel;
  logic [$clog2(N_PROTO_REGS+1)-1:0] pidx;

  irq_fifo_lockout #(.W(PW)) u_lock (
    .clk(clk), .rst_n(rst_n), .evt(proto_evt),
    .fifo_empty(dma_fifo_empty), .post(proto_post)
  );

  irq_gap_timer #(.GAP(GAP_CYCLES)) u_gap (
    .clk(clk), .rst_n(rst_n), .start(rd_clr),
    .active(gap_act), .promote(gap_promote)
  );

  assign sip = |(vis_p & (proto_ien | PROTO_FATAL));
  assign dip = |(vis_d & (dma_ien | DMA_FATAL));

  genvar gi;
  generate
    for (gi = 0; gi < N_PROTO_REGS; gi++) begin : g_proto
      assign clr_p[gi] = rd_en && (addr == ADDR_W'(gi));
      irq_status_bank #(.W(REG_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .evt(proto_post[gi*REG_W +: REG_W]),
        .push(sip || gap_act),
        .promote(gap_promote),
        .clr(clr_p[gi]),
        .vis(vis_p[gi*REG_W +: REG_W]),
        .stk(stk_p[gi*REG_W +: REG_W])
      );
    end
  endgenerate

  assign clr_d  = rd_en && (addr == A_DMA);
  assign rd_clr = (|clr_p) || clr_d;

  irq_status_bank #(.W(REG_W)) u_dma_bank (
    .clk(clk), .rst_n(rst_n), .evt(dma_evt),
    .push(dip || gap_act), .promote(gap_promote), .clr(clr_d),
    .vis(vis_d), .stk(stk_d)
  );

  // register read decode
  always_comb begin
    sel  = SEL_NONE;
    pidx = '0;
    if (addr < A_DMA) begin
      sel  = SEL_PROTO;
      pidx = $bits(pidx)'(addr);
    end else if (addr == A_DMA) begin
      sel = SEL_DMA;
    end else if (addr == A_PEND) begin
      sel = SEL_PEND;
    end
  end

  always_comb begin
    rd_data = '0;
    case (sel)
      SEL_PROTO: rd_data = vis_p[pidx*REG_W +: REG_W];
      SEL_DMA:   rd_data = vis_d;
      SEL_PEND:  rd_data = {{(REG_W-2){1'b0}}, dip, sip};
      default:   rd_data = '0;
    endcase
  end

  // FIFO clear control
  always_comb begin
    dclr_d = 1'b0;
    pclr_d = 1'b0;
    if (wr_en && sel == SEL_PEND) begin
      dclr_d = wr_data[0];
      pclr_d = wr_data[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dclr_q <= 1'b0;
      pclr_q <= 1'b0;
    end else begin
      dclr_q <= dclr_d;
      pclr_q <= pclr_d;
    end
  end

  assign dma_fifo_clr   = dclr_q;
  assign proto_fifo_clr = pclr_q;
  assign irq_n          = !((sip || dip) && !gap_act);

  // R3: request released for three cycles after a clearing read (GAP_CYCLES >= 3)
  p_gap_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> irq_n);
  p_gap_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_clr) |=> irq_n);
  p_gap_c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_clr, 2) |=> irq_n);
  // R6: a visible fatal bit outside the gap always drives the request
  p_fatal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (((vis_p & PROTO_FATAL) != '0 || (vis_d & DMA_FATAL) != '0) && !gap_act) |-> !irq_n);
  // R9: clear pulses last a single cycle when writes are not back to back
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_fifo_clr && !$past(wr_en)) |-> 1'b0);
endmodule

// File: tb/irq_stack_ctrl_tb.sv
module irq_stack_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic [15:0] proto_evt, proto_ien;
  logic [7:0]  dma_evt, dma_ien, wr_data, rd_data;
  logic        dma_fifo_empty, rd_en, wr_en, irq_n, dma_fifo_clr, proto_fifo_clr;
  logic [1:0]  addr;

  localparam logic [15:0] P_FATAL = 16'h0101;
  localparam logic [7:0]  D_FATAL = 8'h01;
  localparam int GAP = 3;

  always #5 clk = ~clk;

  irq_stack_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .proto_evt(proto_evt), .dma_evt(dma_evt),
    .proto_ien(proto_ien), .dma_ien(dma_ien), .dma_fifo_empty(dma_fifo_empty),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq_n(irq_n), .dma_fifo_clr(dma_fifo_clr),
    .proto_fifo_clr(proto_fifo_clr)
  );

  // behavioural reference
  logic [15:0] m_vp, m_sp, m_lock;
  logic [7:0]  m_vd, m_sd;
  int          m_gap;
  logic        m_dc, m_pc;
  string       cur_req = "R11";
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  function automatic logic m_sip();
    return |(m_vp & (proto_ien | P_FATAL));
  endfunction
  function automatic logic m_dip();
    return |(m_vd & (dma_ien | D_FATAL));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vp = '0; m_sp = '0; m_lock = '0; m_vd = '0; m_sd = '0;
      m_gap = 0; m_dc = 0; m_pc = 0;
    end else begin
      logic [15:0] post, keepp;
      logic [7:0]  keepd;
      bit sp, dp, prom, stage_p, stage_d;
      sp = m_sip(); dp = m_dip();
      prom = (m_gap == 1);
      if (dma_fifo_empty) begin post = m_lock | proto_evt; m_lock = '0; end
      else begin post = '0; m_lock = m_lock | proto_evt; end
      keepp = m_vp;
      if (rd_en && addr == 2'd0) keepp[7:0]  = '0;
      if (rd_en && addr == 2'd1) keepp[15:8] = '0;
      keepd = (rd_en && addr == 2'd2) ? 8'h00 : m_vd;
      stage_p = sp || (m_gap != 0);
      stage_d = dp || (m_gap != 0);
      if (prom) begin
        m_vp = keepp | m_sp | post; m_sp = '0;
        m_vd = keepd | m_sd | dma_evt; m_sd = '0;
      end else begin
        if (stage_p) begin m_sp = m_sp | post; m_vp = keepp; end
        else m_vp = keepp | post;
        if (stage_d) begin m_sd = m_sd | dma_evt; m_vd = keepd; end
        else m_vd = keepd | dma_evt;
      end
      if (rd_en && addr != 2'd3) m_gap = GAP;
      else if (m_gap > 0) m_gap = m_gap - 1;
      m_dc = wr_en && addr == 2'd3 && wr_data[0];
      m_pc = wr_en && addr == 2'd3 && wr_data[1];
    end
  end

  function automatic logic [7:0] m_rd();
    case (addr)
      2'd0: return m_vp[7:0];
      2'd1: return m_vp[15:8];
      2'd2: return m_vd;
      default: return {6'b0, m_dip(), m_sip()};
    endcase
  endfunction

  always @(posedge clk) begin
    #3;
    if (!done) begin
      logic exp_irq;
      exp_irq = !((m_sip() || m_dip()) && m_gap == 0);
      n_cmp++;
      if (irq_n !== exp_irq) begin
        n_bad++;
        $display("FAIL %s irq_n actual=%b expected=%b t=%0t", cur_req, irq_n, exp_irq, $time);
      end
      n_cmp++;
      if (rd_data !== m_rd()) begin
        n_bad++;
        $display("FAIL %s rd_data actual=%h expected=%h t=%0t", cur_req, rd_data, m_rd(), $time);
      end
      n_cmp++;
      if ({dma_fifo_clr, proto_fifo_clr} !== {m_dc, m_pc}) begin
        n_bad++;
        $display("FAIL %s fifo_clr actual=%b%b expected=%b%b", cur_req,
                 dma_fifo_clr, proto_fifo_clr, m_dc, m_pc);
      end
    end
  end

  task automatic cyc(input logic [15:0] pe, input logic [7:0] de,
                     input logic rd, input logic wr, input logic [1:0] a,
                     input logic [7:0] wd);
    @(negedge clk);
    proto_evt = pe; dma_evt = de; rd_en = rd; wr_en = wr; addr = a; wr_data = wd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(16'h0, 8'h0, 1'b0, 1'b0, 2'd3, 8'h0);
  endtask

  task automatic rd(input logic [1:0] a);
    cyc(16'h0, 8'h0, 1'b1, 1'b0, a, 8'h0);
  endtask

  task automatic flush();
    for (int a = 0; a < 3; a++) begin rd(2'(a)); idle(5); end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; proto_evt = 0; dma_evt = 0; rd_en = 0; wr_en = 0; addr = 2'd3;
    wr_data = 0; proto_ien = 16'hFFFF; dma_ien = 8'hFF; dma_fifo_empty = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2);
    cur_req = "R1";  cyc(16'h0008, 8'h0, 0, 0, 2'd0, 0); idle(2);
    cur_req = "R2";  idle(2); rd(2'd1); idle(1);
    cur_req = "R3";  rd(2'd0); idle(6);
    cur_req = "R4";  cyc(16'h0400, 8'h0, 0, 0, 2'd1, 0); idle(1);
    cyc(16'h0010, 8'h0, 0, 0, 2'd0, 0); idle(2);
    rd(2'd1); idle(5); rd(2'd0); idle(5);
    cur_req = "R3";  cyc(16'h0002, 8'h0, 0, 0, 2'd0, 0);
    cyc(16'h0004, 8'h0, 1, 0, 2'd0, 0); idle(6); flush();
    cur_req = "R10"; cyc(16'h0, 8'h02, 0, 0, 2'd2, 0); idle(1);
    rd(2'd2); cyc(16'h0, 8'h04, 0, 0, 2'd2, 0);
    cyc(16'h0200, 8'h0, 0, 0, 2'd2, 0); cyc(16'h0, 8'h08, 0, 0, 2'd2, 0);
    idle(4); flush();
    cur_req = "R5";  proto_ien = 16'hFFFD;
    cyc(16'h0002, 8'h0, 0, 0, 2'd0, 0); idle(3);
    cyc(16'h0004, 8'h0, 0, 0, 2'd0, 0); idle(3); flush();
    proto_ien = 16'hFFFF;
    cur_req = "R6";  proto_ien = 16'h0000; dma_ien = 8'h00;
    cyc(16'h0100, 8'h0, 0, 0, 2'd1, 0); idle(2); flush();
    cyc(16'h0, 8'h01, 0, 0, 2'd2, 0); idle(2); flush();
    cyc(16'h0040, 8'h02, 0, 0, 2'd0, 0); idle(2); flush();
    proto_ien = 16'hFFFF; dma_ien = 8'hFF;
    cur_req = "R7";  cyc(16'h0220, 8'h30, 0, 0, 2'd0, 0); idle(1);
    rd(2'd3); idle(1); flush(); flush();
    cur_req = "R8";  dma_fifo_empty = 0;
    cyc(16'h0040, 8'h0, 0, 0, 2'd0, 0); idle(3);
    cyc(16'h8000, 8'h08, 0, 0, 2'd2, 0); idle(2);
    dma_fifo_empty = 1; idle(3); flush(); flush();
    cur_req = "R9";  cyc(16'h0, 8'h0, 0, 1, 2'd3, 8'h01); idle(1);
    cyc(16'h0, 8'h0, 0, 1, 2'd3, 8'h02); idle(1);
    cyc(16'h0, 8'h0, 0, 1, 2'd3, 8'h03); idle(1);
    cyc(16'h0, 8'h0, 0, 1, 2'd0, 8'h03); idle(2);
    done = 1;
    summary();
    $finish;
  end
endmodule